// File: doc/BRIEF.md
# Group-Bypass Binary Adder

This block adds two unsigned words and a carry-in and returns the word-wide sum and the carry-out. The word is cut into equal slices. Inside a slice, each bit works out whether it passes a carry (the operand bits differ) or produces one (both bits set). The carry then moves upward one bit at a time through a chain of 2:1 selectors. A slice whose bits all pass a carry sends its incoming carry straight to its outgoing carry, so a long carry can jump over whole slices instead of crossing every bit.

The width and the slice size are parameters. Elaboration stops with an error when the slice size does not divide the width. A parameter picks between a purely combinational result and a single output register, which helps with timing. With the register, the sum and carry-out appear one clock after the operands and clear to zero under synchronous active-high reset.

Top module: `csk_adder`

## Requirements
- R1: Each bit's pass term is the XOR of its two operand bits and its produce term is their AND; the sum bit is the pass term XOR the carry entering that bit.
- R2: The carry leaving a bit comes from a 2:1 selector: the carry entering the bit when the pass term is 1, otherwise the bit of operand `a`.
- R3: For any operands and carry-in, {`cout`,`sum`} equals the full-precision value a + b + cin.
- R4: The word is split into WIDTH/GRP slices of GRP bits. A slice's bypass flag is the AND of its GRP pass terms, so no bit of a flagged slice has both operand bits set.
- R5: When a slice's bypass flag is 1, the carry leaving the slice equals the carry entering it. With a = all ones, b = 0 and cin = 1, the result is sum = 0 and cout = 1; with cin = 0 it is sum = all ones and cout = 0.
- R6: A slice's outgoing carry is the OR of its rippled carry and (bypass flag AND incoming carry). A carry produced at bit 0 that must reach the top (a = 1, b = all ones) gives sum = 0 and cout = 1.
- R7: `cout` is the carry leaving the most significant slice and equals bit WIDTH of a + b + cin.
- R8: With REG_OUT = 1, `sum` and `cout` show the result for the operands present at the previous rising edge of `clk`, and are 0 in the cycle after a clock edge where `rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum of a, b and cin, modulo 2^WIDTH |
| cout | output | 1 | Carry out of the top slice |

## Verification
The hardest case to reach is a carry that begins at bit 0 and travels the full worst-case route. On that route it ripples to the top of the lowest slice, jumps every middle slice through its bypass flag, and then ripples through the top slice. Random operands almost never set every pass term across several slices at once. Directed vectors therefore build the route directly: all ones added to zero with both carry-in values, 1 added to all ones, and operands whose slices mix produce, pass and kill bits at slice boundaries. A narrow combinational instance of the adder is also checked exhaustively.

// File: rtl/csk_pkg.sv
package csk_pkg;

    // per-bit carry behaviour: pass the incoming carry or produce one
    typedef struct packed {
        logic prop;
        logic gen;
    } pg_bit_t;

    // one slice's outcome
    typedef struct packed {
        logic prop_all;
        logic rip_out;
        logic carry_out;
    } grp_stat_t;

    function automatic pg_bit_t make_pg(input logic x, input logic y);
        pg_bit_t r;
        r.prop = x ^ y;
        r.gen  = x & y;
        return r;
    endfunction

    function automatic logic sel2(input logic s, input logic d1, input logic d0);
        return s ? d1 : d0;
    endfunction

endpackage

// File: rtl/csk_pg_gen.sv
module csk_pg_gen
    import csk_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]    a,
    input  logic [WIDTH-1:0]    b,
    output pg_bit_t [WIDTH-1:0] pg
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pg[i] = make_pg(a[i], b[i]);
    end

endmodule

// File: rtl/csk_group.sv
module csk_group
    import csk_pkg::*;
#(
    parameter int GRP = 4
) (
    input  pg_bit_t [GRP-1:0] pg,
    input  logic [GRP-1:0]    a_bits,
    input  logic              c_in,
    output logic [GRP-1:0]    s_out,
    output grp_stat_t         stat
);

    logic [GRP:0] chain;

    assign chain[0] = c_in;

    for (genvar j = 0; j < GRP; j++) begin : g_cell
        // carry selector: pass when propagating, else operand bit (== gen)
        assign chain[j+1] = sel2(pg[j].prop, chain[j], a_bits[j]);
        assign s_out[j]   = pg[j].prop ^ chain[j];
    end

    logic all_p;
    always_comb begin
        all_p = 1'b1;
        for (int j = 0; j < GRP; j++) begin
            all_p = all_p & pg[j].prop;
        end
    end

    assign stat.prop_all  = all_p;
    assign stat.rip_out   = chain[GRP];
    assign stat.carry_out = chain[GRP] | (all_p & c_in);

endmodule

// File: rtl/csk_out_stage.sv
module csk_out_stage #(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_sum,
    input  logic             d_cout,
    output logic [WIDTH-1:0] q_sum,
    output logic             q_cout
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q_sum  <= '0;
                q_cout <= 1'b0;
            end else begin
                q_sum  <= d_sum;
                q_cout <= d_cout;
            end
        end
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst;
        assign q_sum  = d_sum;
        assign q_cout = d_cout;
    end

endmodule

// File: rtl/csk_adder.sv
module csk_adder
    import csk_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int GRP     = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int NGRP = WIDTH / GRP;

    if ((WIDTH % GRP) != 0 || GRP < 1) begin : g_bad_cfg
        $error("csk_adder: GRP must divide WIDTH");
    end

    pg_bit_t [WIDTH-1:0] pg;
    logic [NGRP:0]       grp_carry;
    logic [NGRP-1:0]     grp_prop;
    logic [WIDTH-1:0]    raw_sum;

    csk_pg_gen #(.WIDTH(WIDTH)) i_pg (
        .a  (a),
        .b  (b),
        .pg (pg)
    );

    assign grp_carry[0] = cin;

    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        grp_stat_t st;
        csk_group #(.GRP(GRP)) i_grp (
            .pg     (pg[g*GRP +: GRP]),
            .a_bits (a[g*GRP +: GRP]),
            .c_in   (grp_carry[g]),
            .s_out  (raw_sum[g*GRP +: GRP]),
            .stat   (st)
        );
        assign grp_prop[g]    = st.prop_all;
        assign grp_carry[g+1] = st.carry_out;
    end

    csk_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) i_out (
        .clk    (clk),
        .rst    (rst),
        .d_sum  (raw_sum),
        .d_cout (grp_carry[NGRP]),
        .q_sum  (sum),
        .q_cout (cout)
    );

endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
    parameter int WIDTH   = 32,
    parameter int GRP     = 4,
    parameter bit REG_OUT = 1'b1,
    localparam int NGRP   = WIDTH / GRP
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [NGRP:0]    grp_carry,
    input logic [NGRP-1:0]  grp_prop
);

    logic [WIDTH:0] full;
    assign full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        AST_SKIP_PASSES_CARRY: assert property (@(posedge clk) disable iff (rst)
            grp_prop[g] |-> (grp_carry[g+1] == grp_carry[g])); // R5
        AST_SKIP_NO_GENERATE: assert property (@(posedge clk) disable iff (rst)
            grp_prop[g] |-> ((a[g*GRP +: GRP] & b[g*GRP +: GRP]) == '0)); // R4
    end

    if (REG_OUT) begin : g_reg
        AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> ({cout, sum} == $past(full))); // R3
        AST_COUT_TOP_GROUP: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (cout == $past(grp_carry[NGRP]))); // R7
        AST_RESET_CLEARS: assert property (@(posedge clk)
            $past(rst) |-> (sum == '0 && !cout)); // R8
    end else begin : g_comb
        AST_RESULT_COMB: assert property (@(posedge clk) disable iff (rst)
            {cout, sum} == full); // R3
        AST_COUT_TOP_COMB: assert property (@(posedge clk) disable iff (rst)
            cout == grp_carry[NGRP]); // R7
    end

endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .GRP(GRP), .REG_OUT(REG_OUT)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .a         (a),
    .b         (b),
    .cin       (cin),
    .sum       (sum),
    .cout      (cout),
    .grp_carry (grp_carry),
    .grp_prop  (grp_prop)
);

// File: tb/test_csk_adder.sv
`timescale 1ns/1ps
module test_csk_adder;

    localparam int W  = 32;
    localparam int K  = 4;
    localparam int SW = 4;
    localparam int SK = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0, b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    logic [SW-1:0] sa = '0, sb = '0;
    logic          scin = 1'b0;
    logic [SW-1:0] ssum;
    logic          scout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    csk_adder #(.WIDTH(W), .GRP(K), .REG_OUT(1'b1)) i_csk_adder (
        .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );

    csk_adder #(.WIDTH(SW), .GRP(SK), .REG_OUT(1'b0)) i_small (
        .clk(clk), .rst(rst), .a(sa), .b(sb), .cin(scin), .sum(ssum), .cout(scout)
    );

    task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: apply operands at the falling edge and queue the expected result
    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c, input string tag);
        @(negedge clk);
        a   = x;
        b   = y;
        cin = c;
        exp_q.push_back({1'b0, x} + {1'b0, y} + {{W{1'b0}}, c});
        tag_q.push_back(tag);
    endtask

    // monitor: each result appears one edge after its operands were applied
    always @(posedge clk) begin
        #1;
        if (!rst && exp_q.size() > 0) begin
            logic [W:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {cout, sum}, e);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset clears outputs", {cout, sum}, '0);
        rst = 1'b0;

        // R5: all bits propagate, carry skips every slice
        drive('1, '0, 1'b1, "R5 all-propagate cin=1");
        drive('1, '0, 1'b0, "R5 all-propagate cin=0");
        drive('0, '1, 1'b1, "R5 all-propagate swapped");
        // R6: carry produced at bit 0 travels the worst-case route
        drive(32'h0000_0001, '1, 1'b0, "R6 bit0 generate to top");
        drive(32'h8000_0001, 32'h7FFF_FFFF, 1'b0, "R6 generate plus top");
        // R2: selector picks operand bit when not propagating
        drive(32'h0000_00F0, 32'h0000_0010, 1'b0, "R2 slice boundary carry");
        drive(32'h0F0F_0F0F, 32'h00F0_00F0, 1'b1, "R2 mixed propagate");
        // R1: no carries at all
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R1 pure xor");
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R7 max operands");
        drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R7 top carry only");
        drive('0, '0, 1'b0, "R1 zero");
        for (int i = 0; i < 400; i++) begin
            drive($urandom, $urandom, 1'($urandom), "R3 random");
        end
        for (int i = 0; i < 100; i++) begin
            logic [W-1:0] r;
            r = $urandom;
            drive(r, ~r, 1'($urandom), "R4 random full-propagate");
        end
        @(negedge clk);
        @(negedge clk);

        // R8: reset in mid-stream clears registered output
        drive(32'h1234_5678, 32'h1111_1111, 1'b1, "R8 before reset");
        @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        tag_q.delete();
        @(negedge clk);
        check("R8 mid-run reset", {cout, sum}, '0);
        rst = 1'b0;

        // exhaustive narrow combinational instance
        for (int x = 0; x < (1 << SW); x++) begin
            for (int y = 0; y < (1 << SW); y++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [SW:0] e;
                    sa = SW'(x);
                    sb = SW'(y);
                    scin = 1'(c);
                    #1;
                    e = {1'b0, sa} + {1'b0, sb} + {{SW{1'b0}}, scin};
                    check("R3 R7 exhaustive narrow", W'({scout, ssum}) , W'(e));
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule